// File: doc/BRIEF.md
# Saturating Wide Accumulator

This block holds a running sum at the back end of a multiply-accumulate datapath. On each clock edge where the input is marked valid, the incoming word is extended to the width of the sum register and added to it. The register may be wider than the input, so more terms can be added before the sum leaves its range. A synchronous clear empties the register and takes priority over any addition in the same cycle.

Out-of-range results are handled in one of two ways, selected per cycle by a mode pin. In wrap mode the result keeps only its low bits. In clamp mode it is held at the limit it crossed. A parameter selects unsigned or two's-complement arithmetic. With signed arithmetic, clamping goes to the most positive or the most negative value, depending on the direction of the overflow. An overflow in either mode sets a sticky flag, which stays set until the next clear. The sum and the flag drive the outputs directly at all times.

Top module: `sat_accum`

## Requirements
- R1: On a rising edge with `in_valid` high and `clr` low, `acc_out` becomes the previous `acc_out` plus the input, with effect on the next edge's output.
- R2: `clr` high loads zero into `acc_out` and drops `ovf_flag` on that edge, whatever `in_valid` and `in_data` hold.
- R3: With `clr` and `in_valid` both low, `acc_out` and `ovf_flag` keep their values, whatever `in_data` carries.
- R4: With `sat_en` low, a result outside the representable range keeps only its low `ACC_W` bits (modulo 2^ACC_W).
- R5: In unsigned mode (`SIGNED_MODE`=0) with `sat_en` high, a result above 2^ACC_W-1 is replaced by 2^ACC_W-1 (all ones).
- R6: In signed mode (`SIGNED_MODE`=1) with `sat_en` high, a positive overflow gives 2^(ACC_W-1)-1 and a negative overflow gives -2^(ACC_W-1).
- R7: Any accumulation that overflows, in either mode, sets `ovf_flag`. The flag stays high through later cycles until a clear.
- R8: While `rst_n` is low at a clock edge, `acc_out` and `ovf_flag` are cleared to zero.
- R9: When `IN_W` < `ACC_W`, the input is zero-extended in unsigned mode and sign-extended from bit `IN_W`-1 in signed mode. For example, 8'hF0 adds 240 unsigned or -16 signed.
- R10: `sat_en` is sampled on each accumulating edge independently, so the overflow handling may switch between consecutive additions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of sum and flag, has priority |
| in_valid | input | 1 | Adds `in_data` on this edge when high |
| in_data | input | IN_W | Term to accumulate |
| sat_en | input | 1 | 1 = clamp at range limit, 0 = wrap |
| acc_out | output | ACC_W | Running sum |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The collision that matters is a clear arriving in the same cycle as a valid input, and in particular one that would overflow. That is the case where the clear must beat both the addition and the flag update. The bench drives such cycles directly, after a wrap-around has already set the flag. It also produces them at random, since roughly one cycle in sixteen asserts `clr` while `in_valid` is often high. Each of these cycles is judged by requiring zero sum and a low flag on the next edge. Both an unsigned instance and a signed instance are checked against bench models after every cycle.

// File: rtl/sat_accum_pkg.sv
package sat_accum_pkg;

    // Treatment of a sum that leaves its representable range
    typedef enum logic {
        OVF_WRAP  = 1'b0,
        OVF_CLAMP = 1'b1
    } ovf_mode_e;

endpackage

// File: rtl/sat_accum_extend.sv
module sat_accum_extend #(
    parameter int IN_W        = 64,
    parameter int ACC_W       = 64,
    parameter bit SIGNED_MODE = 1'b0
) (
    input  logic [IN_W-1:0]  in_word,
    output logic [ACC_W-1:0] ext_word
);
    localparam int PAD_W = ACC_W - IN_W;

    generate
        if (PAD_W == 0) begin : g_same
            assign ext_word = in_word;
        end else if (SIGNED_MODE) begin : g_sign
            assign ext_word = {{PAD_W{in_word[IN_W-1]}}, in_word};
        end else begin : g_zero
            assign ext_word = {{PAD_W{1'b0}}, in_word};
        end
    endgenerate
endmodule

// File: rtl/sat_accum_add.sv
module sat_accum_add #(
    parameter int ACC_W       = 64,
    parameter bit SIGNED_MODE = 1'b0
) (
    input  logic [ACC_W-1:0] op_a,
    input  logic [ACC_W-1:0] op_b,
    output logic [ACC_W-1:0] sum_raw,
    output logic             ovf,
    output logic             ovf_neg
);
    localparam int WIDE_W = ACC_W + 1;

    logic [WIDE_W-1:0] wide_a;
    logic [WIDE_W-1:0] wide_b;
    logic [WIDE_W-1:0] wide_sum;

    generate
        if (SIGNED_MODE) begin : g_signed
            assign wide_a  = {op_a[ACC_W-1], op_a};
            assign wide_b  = {op_b[ACC_W-1], op_b};
            // guard bit disagrees with the result sign bit: out of range
            assign ovf     = wide_sum[ACC_W] ^ wide_sum[ACC_W-1];
            assign ovf_neg = wide_sum[ACC_W];
        end else begin : g_unsigned
            assign wide_a  = {1'b0, op_a};
            assign wide_b  = {1'b0, op_b};
            assign ovf     = wide_sum[ACC_W];
            assign ovf_neg = 1'b0;
        end
    endgenerate

    assign wide_sum = wide_a + wide_b;
    assign sum_raw  = wide_sum[ACC_W-1:0];
endmodule

// File: rtl/sat_accum_clamp.sv
module sat_accum_clamp
    import sat_accum_pkg::*;
#(
    parameter int ACC_W       = 64,
    parameter bit SIGNED_MODE = 1'b0
) (
    input  logic [ACC_W-1:0] sum_raw,
    input  logic             ovf,
    input  logic             ovf_neg,
    input  ovf_mode_e        mode,
    output logic [ACC_W-1:0] sum_out
);
    localparam logic [ACC_W-1:0] LIM_HI = SIGNED_MODE ? {1'b0, {(ACC_W-1){1'b1}}}
                                                      : {ACC_W{1'b1}};
    localparam logic [ACC_W-1:0] LIM_LO = SIGNED_MODE ? {1'b1, {(ACC_W-1){1'b0}}}
                                                      : {ACC_W{1'b0}};

    always_comb begin
        sum_out = sum_raw;
        if (ovf && (mode == OVF_CLAMP)) begin
            sum_out = ovf_neg ? LIM_LO : LIM_HI;
        end
    end
endmodule

// File: rtl/sat_accum.sv
module sat_accum
    import sat_accum_pkg::*;
#(
    parameter int IN_W        = 64,
    parameter int ACC_W       = 64,
    parameter bit SIGNED_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             sat_en,
    output logic [ACC_W-1:0] acc_out,
    output logic             ovf_flag
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovf;
    } state_t;

    state_t st_d, st_q;

    logic [ACC_W-1:0] term_ext;
    logic [ACC_W-1:0] sum_raw;
    logic [ACC_W-1:0] sum_lim;
    logic             add_ovf;
    logic             add_neg;
    ovf_mode_e        mode;

    assign mode = sat_en ? OVF_CLAMP : OVF_WRAP;

    sat_accum_extend #(
        .IN_W        (IN_W),
        .ACC_W       (ACC_W),
        .SIGNED_MODE (SIGNED_MODE)
    ) u_extend (
        .in_word  (in_data),
        .ext_word (term_ext)
    );

    sat_accum_add #(
        .ACC_W       (ACC_W),
        .SIGNED_MODE (SIGNED_MODE)
    ) u_add (
        .op_a    (st_q.acc),
        .op_b    (term_ext),
        .sum_raw (sum_raw),
        .ovf     (add_ovf),
        .ovf_neg (add_neg)
    );

    sat_accum_clamp #(
        .ACC_W       (ACC_W),
        .SIGNED_MODE (SIGNED_MODE)
    ) u_clamp (
        .sum_raw (sum_raw),
        .ovf     (add_ovf),
        .ovf_neg (add_neg),
        .mode    (mode),
        .sum_out (sum_lim)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (in_valid) begin
            st_d.acc = sum_lim;
            st_d.ovf = st_q.ovf | add_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out  = st_q.acc;
    assign ovf_flag = st_q.ovf;
endmodule

// File: rtl/sat_accum_chk.sv
module sat_accum_chk #(
    parameter int ACC_W       = 64,
    parameter bit SIGNED_MODE = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             in_valid,
    input logic             sat_en,
    input logic [ACC_W-1:0] acc_out,
    input logic             ovf_flag
);
    localparam logic [ACC_W-1:0] POS_TOP = {1'b0, {(ACC_W-1){1'b1}}};

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_out == '0) && !ovf_flag);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !in_valid) |=> ($stable(acc_out) && $stable(ovf_flag)));

    // R7
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr) |=> ovf_flag);

    // R7
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(in_valid));

    generate
        if (SIGNED_MODE) begin : g_sgn
            // R6
            top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sat_en && in_valid && !clr && (acc_out == POS_TOP)) |=> !acc_out[ACC_W-1]);
        end else begin : g_uns
            // R5
            no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sat_en && in_valid && !clr) |=> (acc_out >= $past(acc_out)));
        end
    endgenerate
endmodule

bind sat_accum sat_accum_chk #(
    .ACC_W       (ACC_W),
    .SIGNED_MODE (SIGNED_MODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .sat_en   (sat_en),
    .acc_out  (acc_out),
    .ovf_flag (ovf_flag)
);

// File: tb/sat_accum_bench.sv
module sat_accum_bench;
    localparam int IW = 8;
    localparam int AW = 10;
    localparam longint UMAX = 1023;
    localparam longint SMAX = 511;
    localparam longint SMIN = -512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_data = '0;
    logic          sat_en = 1'b0;
    logic [AW-1:0] acc_u, acc_s;
    logic          ovf_u, ovf_s;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    longint m_u = 0, m_s = 0;
    bit     f_u = 1'b0, f_s = 1'b0;

    always #10 clk = ~clk;

    sat_accum #(.IN_W(IW), .ACC_W(AW), .SIGNED_MODE(1'b0)) u_sat_accum (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_data(in_data), .sat_en(sat_en), .acc_out(acc_u), .ovf_flag(ovf_u)
    );

    sat_accum #(.IN_W(IW), .ACC_W(AW), .SIGNED_MODE(1'b1)) u_sat_accum_sgn (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_data(in_data), .sat_en(sat_en), .acc_out(acc_s), .ovf_flag(ovf_s)
    );

    function automatic void model_u(input longint a, input logic [IW-1:0] d, input bit sat,
                                    output longint r, output bit o);
        r = a + longint'(d);
        o = (r > UMAX);
        if (o) r = sat ? UMAX : r - (UMAX + 1);
    endfunction

    function automatic void model_s(input longint a, input logic [IW-1:0] d, input bit sat,
                                    output longint r, output bit o);
        r = a + longint'($signed(d));
        o = 1'b0;
        if (r > SMAX) begin
            o = 1'b1;
            r = sat ? SMAX : r - 1024;
        end else if (r < SMIN) begin
            o = 1'b1;
            r = sat ? SMIN : r + 1024;
        end
    endfunction

    task automatic check(input string tag, input string what, input longint got, input longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "unsigned sum", longint'(acc_u), m_u & UMAX);
        check(tag, "unsigned flag", longint'(ovf_u), longint'(f_u));
        check(tag, "signed sum bits", longint'(acc_s), m_s & UMAX);
        check(tag, "signed flag", longint'(ovf_s), longint'(f_s));
    endtask

    task automatic step(input bit c, input bit v, input bit s, input logic [IW-1:0] d,
                        input string tag);
        longint r;
        bit o;
        @(negedge clk);
        clr = c; in_valid = v; sat_en = s; in_data = d;
        if (c) begin
            m_u = 0; m_s = 0; f_u = 1'b0; f_s = 1'b0;
        end else if (v) begin
            model_u(m_u, d, s, r, o); m_u = r; f_u = f_u | o;
            model_s(m_s, d, s, r, o); m_s = r; f_s = f_s | o;
        end
        @(posedge clk);
        #2;
        compare_all(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        compare_all("R8");                       // R8 reset state
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 1, 0, 8'd5, "R1");
        step(0, 1, 0, 8'd7, "R1");               // 12
        step(0, 0, 0, 8'd99, "R3");              // idle, data ignored
        step(0, 0, 1, 8'hFF, "R3");
        step(0, 1, 0, 8'hF0, "R9");              // +240 unsigned, -16 signed
        step(1, 1, 0, 8'h33, "R2");              // clear beats valid

        for (int i = 0; i < 5; i++) step(0, 1, 0, 8'h7F, "R4");   // signed wraps on 5th
        for (int i = 0; i < 4; i++) step(0, 1, 0, 8'hFF, "R4");   // unsigned wraps
        step(0, 1, 0, 8'd1, "R7");               // flags stay set
        step(0, 0, 0, 8'd0, "R7");
        step(1, 1, 1, 8'h7F, "R2");              // clear with pending overflow

        for (int i = 0; i < 9; i++) step(0, 1, 1, 8'h7F, "R5");   // unsigned to 1023, signed to 511
        step(0, 1, 1, 8'h7F, "R6");              // held at positive limit
        step(1, 0, 0, 8'd0, "R2");
        for (int i = 0; i < 6; i++) step(0, 1, 1, 8'h80, "R6");   // signed to -512
        step(0, 1, 0, 8'h80, "R10");             // wrap mode right after clamp
        step(0, 1, 1, 8'h80, "R10");
        step(0, 1, 0, 8'hFF, "R10");

        for (int i = 0; i < 400; i++) begin
            step(($urandom % 16) == 0, ($urandom % 4) != 0, $urandom % 2,
                 IW'($urandom), "R1");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule